// File: doc/BRIEF.md
# Double-Late-Write Pipelined SRAM Engine

This block is a synchronous single-data-rate memory array with one command per clock. Each rising edge captures a combined enable, an advance/load flag, an active-low write enable and an address. A read returns its word through an output register, so the data is valid one cycle after the edge that follows the command. A write takes its data and its active-low byte-lane enables two edges after the command. Because of this, a host can interleave reads and writes on every cycle without leaving an idle slot on the shared data path.

An internal burst generator keeps the last loaded address. On an advance command it steps the two low address bits in linear order and wraps them, leaving the upper bits as they were. The burst keeps the direction of its load command, and it stops when the block is deselected. Writes that are still in flight are compared against every new read, so a read always returns the newest data, merged byte by byte.

Timing is fixed and there is no flow control: every port is sampled or driven on a fixed edge. The host cannot be back-pressured, and it must present write data exactly two edges after each accepted write command.

Top module: `dlw_sram`

## Requirements
- R1: While `rst` is high, and in the cycle after the last reset edge, `rdata_oe` is low and no burst is active.
- R2: A load read (`cmd_en`=1, `adv_ld`=0, `we_n`=1) at edge n puts the addressed word on `rdata` with `rdata_oe` high after edge n+1.
- R3: A load write (`cmd_en`=1, `adv_ld`=0, `we_n`=0) at edge n stores `wdata` as sampled at edge n+2.
- R4: `bw_n[k]` sampled at edge n+2 guards byte lane k (bits 8k+7..8k). Only lanes whose bit is 0 are written, and the other lanes keep their old contents.
- R5: Alternating read and write commands on consecutive edges each complete correctly, with no idle cycle between them.
- R6: An advance command (`cmd_en`=1, `adv_ld`=1) during an active burst uses the previous burst address with bits [1:0] incremented modulo 4 and bits [AW-1:2] unchanged. The `addr` input is ignored, so the fifth access returns to the start address.
- R7: A load issued part way through a burst starts a new burst from the new address, which gives bursts of 2, 3 or 4 accesses.
- R8: `cmd_en`=0 deselects the block and ends the burst. An advance command given with no active burst performs no access: no read output and no array change.
- R9: A read whose address matches a write issued one or two edges earlier returns that write's lanes merged over the older contents.
- R10: `rdata_oe` is low in the cycle after edge n+1 whenever the command at edge n was a write or a deselect.
- R11: An advance command keeps the read or write direction of the load that began the burst, whatever the state of `we_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_en | input | 1 | Combined chip enable, high selects the block |
| adv_ld | input | 1 | 0 loads `addr` as a new command, 1 advances the burst |
| we_n | input | 1 | Direction of a load: 0 write, 1 read |
| addr | input | AW | Word address for a load |
| bw_n | input | DW/8 | Byte-lane write enables, active low, sampled with write data |
| wdata | input | DW | Write data, sampled two edges after its command |
| rdata | output | DW | Registered read data |
| rdata_oe | output | 1 | High while `rdata` carries valid read data |

## Verification
Three things can fall on the same edge: a write commits to the array, a read captures its output, and that same write's data is forwarded into the read. The bench provokes this by following a write to an address with a read of that address on the next edge, and again with one unrelated command in between, using partial lane masks. A second collision comes from deselecting or reloading part way through a burst while the advance logic would otherwise step. Each output word is judged against a memory image that the bench updates at the data edge of each write, and against its own model of the burst address.

// File: rtl/dlw_sram_pkg.sv
package dlw_sram_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/dlw_cmd_seq.sv
module dlw_cmd_seq
  import dlw_sram_pkg::*;
#(
  parameter int AW      = 6,
  parameter int BL_BITS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_en,
  input  logic          adv_ld,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output op_e           op,
  output logic [AW-1:0] op_addr
);
  logic          b_act;
  logic          b_wr;
  logic [AW-1:0] b_addr;
  logic [AW-1:0] step_addr;
  logic [BL_BITS-1:0] low_next;

  assign low_next  = b_addr[BL_BITS-1:0] + 1'b1;
  assign step_addr = {b_addr[AW-1:BL_BITS], low_next};

  always_comb begin
    op      = OP_IDLE;
    op_addr = addr;
    if (cmd_en) begin
      if (!adv_ld) begin
        op      = we_n ? OP_READ : OP_WRITE;
        op_addr = addr;
      end else if (b_act) begin
        op      = b_wr ? OP_WRITE : OP_READ;
        op_addr = step_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_act  <= 1'b0;
      b_wr   <= 1'b0;
      b_addr <= '0;
    end else if (!cmd_en) begin
      b_act <= 1'b0;
    end else if (!adv_ld) begin
      b_act  <= 1'b1;
      b_wr   <= !we_n;
      b_addr <= addr;
    end else if (b_act) begin
      b_addr <= step_addr;
    end
  end
endmodule

// File: rtl/dlw_lane_merge.sv
module dlw_lane_merge
  import dlw_sram_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]        base,
  input  logic [DW-1:0]        upd,
  input  logic [DW/LANE_W-1:0] upd_bw_n,
  input  logic                 hit,
  output logic [DW-1:0]        res
);
  localparam int NB = DW / LANE_W;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign res[g*LANE_W +: LANE_W] = (hit && !upd_bw_n[g]) ?
        upd[g*LANE_W +: LANE_W] : base[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/dlw_store.sv
module dlw_store
  import dlw_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [DW-1:0]        wdata,
  input  logic [DW/LANE_W-1:0] bw_n,
  input  logic                 re,
  input  logic [AW-1:0]        raddr,
  output logic [DW-1:0]        rd_q
);
  localparam int NB    = DW / LANE_W;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (we && !bw_n[g]) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      if (re) lane_q <= lane_mem[raddr];
    end

    assign rd_q[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/dlw_sram.sv
module dlw_sram
  import dlw_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_en,
  input  logic                 adv_ld,
  input  logic                 we_n,
  input  logic [AW-1:0]        addr,
  input  logic [DW/LANE_W-1:0] bw_n,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 rdata_oe
);
  localparam int NB = DW / LANE_W;

  op_e           cur_op;
  logic [AW-1:0] cur_addr;

  dlw_cmd_seq #(.AW(AW), .BL_BITS(2)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .cmd_en  (cmd_en),
    .adv_ld  (adv_ld),
    .we_n    (we_n),
    .addr    (addr),
    .op      (cur_op),
    .op_addr (cur_addr)
  );

  // write slots: s1 one edge old, s2 two edges old (its data is on wdata now)
  logic          s1_wr, s2_wr;
  logic [AW-1:0] s1_addr, s2_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_wr <= 1'b0;
      s2_wr <= 1'b0;
    end else begin
      s1_wr <= (cur_op == OP_WRITE);
      s2_wr <= s1_wr;
    end
    s1_addr <= cur_addr;
    s2_addr <= s1_addr;
  end

  logic [DW-1:0] rd_q;

  dlw_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .we    (s2_wr),
    .waddr (s2_addr),
    .wdata (wdata),
    .bw_n  (bw_n),
    .re    (cur_op == OP_READ),
    .raddr (cur_addr),
    .rd_q  (rd_q)
  );

  // read stage: array word plus the write that commits on the read edge
  logic          rs_vld;
  logic [AW-1:0] rs_addr;
  logic          early_hit;
  logic [DW-1:0] early_data;
  logic [NB-1:0] early_bw;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_vld    <= 1'b0;
      early_hit <= 1'b0;
    end else begin
      rs_vld    <= (cur_op == OP_READ);
      early_hit <= s2_wr && (cur_op == OP_READ) && (s2_addr == cur_addr);
    end
    rs_addr    <= cur_addr;
    early_data <= wdata;
    early_bw   <= bw_n;
  end

  logic [DW-1:0] stage_a;
  logic [DW-1:0] stage_b;
  logic          late_hit;

  assign late_hit = rs_vld && s2_wr && (s2_addr == rs_addr);

  dlw_lane_merge #(.DW(DW)) u_merge_early (
    .base     (rd_q),
    .upd      (early_data),
    .upd_bw_n (early_bw),
    .hit      (early_hit),
    .res      (stage_a)
  );

  dlw_lane_merge #(.DW(DW)) u_merge_late (
    .base     (stage_a),
    .upd      (wdata),
    .upd_bw_n (bw_n),
    .hit      (late_hit),
    .res      (stage_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_oe <= 1'b0;
      rdata    <= '0;
    end else begin
      rdata_oe <= rs_vld;
      if (rs_vld) rdata <= stage_b;
    end
  end
endmodule

// File: rtl/dlw_sram_chk.sv
module dlw_sram_chk (
  input logic clk,
  input logic rst,
  input logic cmd_en,
  input logic adv_ld,
  input logic we_n,
  input logic rdata_oe
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !rdata_oe);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && !adv_ld && we_n) |=> ##1 rdata_oe);

  assert_write_no_oe_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && !adv_ld && !we_n) |=> ##1 !rdata_oe);

  assert_desel_no_oe_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_en |=> ##1 !rdata_oe);

  assert_idle_advance_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && adv_ld && $past(!cmd_en)) |=> ##1 !rdata_oe);
endmodule

bind dlw_sram dlw_sram_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_en   (cmd_en),
  .adv_ld   (adv_ld),
  .we_n     (we_n),
  .rdata_oe (rdata_oe)
);

// File: tb/dlw_sram_test.sv
`timescale 1ns/1ps
module dlw_sram_test;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_en = 1'b0;
  logic          adv_ld = 1'b0;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bw_n = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  always #2 clk = ~clk;

  dlw_sram #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .cmd_en(cmd_en), .adv_ld(adv_ld), .we_n(we_n),
    .addr(addr), .bw_n(bw_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string cur_tag = "R1";
  logic [NB-1:0] lane_mask = '0;

  logic [DW-1:0] ref_mem [1<<AW];
  logic          q0_v = 0, q0_w = 0, q1_v = 0, q1_w = 0;
  logic [AW-1:0] q0_a = '0, q1_a = '0;
  logic          mb_act = 0, mb_wr = 0;
  logic [AW-1:0] mb_addr = '0;

  function automatic logic [DW-1:0] pat(int c);
    return 32'hC3A5_1E0F ^ (c * 32'h0101_1F33);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic adv, input logic wn, input int a);
    logic          nv, nw, exp_oe;
    logic [AW-1:0] na;
    logic [DW-1:0] exp_d;
    cmd_en = en; adv_ld = adv; we_n = wn; addr = a[AW-1:0];
    wdata = pat(cyc); bw_n = lane_mask;
    @(posedge clk);
    if (q1_v && q1_w)
      for (int l = 0; l < NB; l++)
        if (!bw_n[l]) ref_mem[q1_a][l*8 +: 8] = wdata[l*8 +: 8];
    exp_oe = q0_v && !q0_w;
    exp_d  = ref_mem[q0_a];
    nv = 0; nw = 0; na = '0;
    if (!en) mb_act = 0;
    else if (!adv) begin
      nv = 1; nw = !wn; na = a[AW-1:0];
      mb_act = 1; mb_wr = !wn; mb_addr = na;
    end else if (mb_act) begin
      na = (mb_addr & ~AW'(3)) | ((mb_addr + AW'(1)) & AW'(3));
      nv = 1; nw = mb_wr; mb_addr = na;
    end
    q1_v = q0_v; q1_w = q0_w; q1_a = q0_a;
    q0_v = nv;   q0_w = nw;   q0_a = na;
    cyc++;
    @(negedge clk);
    chk(exp_oe ? cur_tag : "R10 oe", {31'd0, rdata_oe}, {31'd0, exp_oe});
    if (exp_oe) chk(cur_tag, rdata, exp_d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", {31'd0, rdata_oe}, 32'd0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {31'd0, rdata_oe}, 32'd0);
    step(1, 1, 1, 5);  // advance right after reset: no burst, no access (R1 R8)

    // R2 R3: fill every word, then read each back
    cur_tag = "R2 R3";
    for (int a = 0; a < (1 << AW); a++) step(1, 0, 0, a);
    idle(2);
    for (int a = 0; a < (1 << AW); a++) step(1, 0, 1, a);
    idle(2);

    // R4: every lane mask pattern
    cur_tag = "R4";
    for (int m = 0; m < (1 << NB); m++) begin
      lane_mask = NB'(m);
      step(1, 0, 0, m);
      idle(2);
      lane_mask = '0;
      step(1, 0, 1, m);
      idle(1);
    end
    idle(1);

    // R5: read/write alternating every edge
    cur_tag = "R5";
    for (int k = 0; k < 32; k++) begin
      step(1, 0, 1, 40 + (k % 8));
      step(1, 0, 0, 40 + ((k + 3) % 8));
    end
    idle(2);

    // R6 R11: four-beat bursts from every start offset, reads then writes
    cur_tag = "R6 R11";
    for (int s = 0; s < 4; s++) begin
      step(1, 0, 1, 20 + s);
      for (int k = 0; k < 5; k++) step(1, 1, k[0], 63 - k);
      step(1, 0, 0, 28 + s);
      for (int k = 0; k < 3; k++) step(1, 1, 1, k);
      idle(2);
      for (int k = 0; k < 4; k++) step(1, 0, 1, 28 + k);
      idle(1);
    end

    // R7: short bursts cut by a new load
    cur_tag = "R7";
    step(1, 0, 1, 9);  step(1, 1, 1, 0);
    step(1, 0, 1, 14); step(1, 1, 1, 0); step(1, 1, 0, 0);
    step(1, 0, 0, 33); step(1, 1, 1, 0);
    step(1, 0, 1, 34); step(1, 1, 1, 0); step(1, 1, 1, 0);
    idle(2);
    step(1, 0, 1, 33); step(1, 0, 1, 34);
    idle(2);

    // R8: deselect ends a burst; advance afterwards does nothing
    cur_tag = "R8";
    step(1, 0, 1, 50); step(1, 1, 1, 0); step(0, 0, 1, 0);
    step(1, 1, 1, 7); step(1, 1, 0, 7);
    step(1, 0, 0, 52); step(0, 0, 1, 0); step(1, 1, 0, 0); step(1, 1, 0, 0);
    idle(3);
    for (int a = 52; a < 56; a++) step(1, 0, 1, a);
    idle(2);

    // R9: reads of pending writes, one and two edges back, partial lanes
    cur_tag = "R9";
    for (int m = 0; m < (1 << NB); m++) begin
      lane_mask = NB'(m);
      step(1, 0, 0, 60); step(1, 0, 1, 60);
      step(1, 0, 0, 61); step(1, 0, 1, 2); step(1, 0, 1, 61);
      step(1, 0, 0, 62); step(1, 0, 0, 62); step(1, 0, 1, 62);
      idle(2);
      lane_mask = '0;
      step(1, 0, 1, 60); step(1, 0, 1, 61); step(1, 0, 1, 62);
      idle(1);
    end
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule